// File: doc/BRIEF.md
# Trigger Veto and Batch Interrupt Controller

This block sits between an external trigger source and a set of digitizer modules. When a trigger arrives while the modules are idle, it does three things. It issues a one-cycle conversion strobe to every module, raises a veto that blocks further triggers, and counts the event. Once the enabled modules all report ready again, the veto drops and the next trigger can be taken. A trigger that arrives while the veto is up is thrown away and counted as lost.

Events are collected in batches. When an accepted trigger brings the event count up to a programmable threshold, the block raises an interrupt to the readout CPU. It then holds both the interrupt and the veto until the CPU has drained the module buffers and issued its reset. That reset acknowledges the interrupt and clears the counters. The veto is released only after a short hold-off, and only once all enabled modules show ready in the same cycle.

Top module: `trig_veto_ctrl`

## Requirements
- R1: While rst_ni is low, veto_o, conv_o and irq_o are 0 and evt_cnt_o and lost_cnt_o are 0.
- R2: A rising edge of trig_i (high now, low in the previous sampled cycle) is accepted when veto_o is low and cpu_rst_i is low. At the next clock edge conv_o goes high for exactly one cycle, veto_o goes high, and evt_cnt_o increments by one.
- R3: Holding trig_i high for many cycles produces at most one accepted trigger. A new acceptance needs trig_i to go low and then high again.
- R4: A rising edge of trig_i while veto_o is high and cpu_rst_i is low is dropped. It produces no conv_o and leaves evt_cnt_o unchanged, and lost_cnt_o increments, saturating at its all-ones value.
- R5: If the event count after acceptance is below thresh_i, the veto is held for HOLD further clock edges. It then falls at the first edge where every enabled module's rdy_i is high.
- R6: A module whose bit in mod_en_i is 0 does not hold the veto, whatever its rdy_i value.
- R7: If the event count after acceptance is at least thresh_i, irq_o rises together with conv_o at the same edge.
- R8: While irq_o is high, irq_o and veto_o stay high regardless of rdy_i until cpu_rst_i is sampled high. After that edge, irq_o is 0 and the veto follows the hold-off and ready rule of R5.
- R9: cpu_rst_i sampled high in any state clears evt_cnt_o, lost_cnt_o and irq_o at that edge. A trigger edge in the same cycle is neither accepted nor counted as lost. If no interrupt is pending, the veto state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | External trigger, synchronous level, rising edge acts |
| mod_en_i | input | N_MOD | Per-module enable for the ready check |
| rdy_i | input | N_MOD | Per-module ready |
| cpu_rst_i | input | 1 | CPU reset/acknowledge, one bit per cycle |
| thresh_i | input | CNT_W | Events per interrupt |
| veto_o | output | 1 | Trigger veto |
| conv_o | output | 1 | One-cycle conversion strobe to modules |
| irq_o | output | 1 | Interrupt to readout CPU |
| evt_cnt_o | output | CNT_W | Accepted events in current batch |
| lost_cnt_o | output | LOST_W | Triggers dropped under veto, saturating |

## Verification
The assertions assume that trig_i, rdy_i, cpu_rst_i and mod_en_i are synchronous to clk_i. They also assume that a module lowers its ready within HOLD cycles of a conversion strobe, so the hold-off never releases the veto on a stale ready. The bench meets these assumptions by changing every input only on the falling edge. Its emulated modules drop ready on the first falling edge after the strobe and stay busy for a configurable latency. Some stimulus deliberately lands on the hard cases: a trigger in the same cycle as the CPU reset, triggers during the hold-off, and a disabled module whose ready is stuck low.

// File: rtl/trig_veto_pkg.sv
package trig_veto_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_WAIT = 2'd2
  } tv_state_e;
endpackage

// File: rtl/tv_edge_det.sv
module tv_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/tv_ready_and.sv
module tv_ready_and #(
  parameter int N_MOD = 4
) (
  input  logic [N_MOD-1:0] en_i,
  input  logic [N_MOD-1:0] rdy_i,
  output logic             all_rdy_o
);
  logic [N_MOD-1:0] ok;

  for (genvar m = 0; m < N_MOD; m++) begin : g_mod
    // disabled module never holds the veto
    assign ok[m] = rdy_i[m] | ~en_i[m];
  end

  assign all_rdy_o = &ok;
endmodule

// File: rtl/tv_sat_cnt.sv
module tv_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= '0;
    else if (clr_i)                  cnt_o <= '0;
    else if (inc_i && cnt_o != MAX)  cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/trig_veto_ctrl.sv
module trig_veto_ctrl
  import trig_veto_pkg::*;
#(
  parameter int N_MOD  = 4,
  parameter int CNT_W  = 8,
  parameter int LOST_W = 8,
  parameter int HOLD   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [N_MOD-1:0]  mod_en_i,
  input  logic [N_MOD-1:0]  rdy_i,
  input  logic              cpu_rst_i,
  input  logic [CNT_W-1:0]  thresh_i,
  output logic              veto_o,
  output logic              conv_o,
  output logic              irq_o,
  output logic [CNT_W-1:0]  evt_cnt_o,
  output logic [LOST_W-1:0] lost_cnt_o
);
  localparam int HOLD_W = $clog2(HOLD + 2);
  localparam logic [HOLD_W-1:0] HOLD_LD = HOLD_W'(HOLD);

  tv_state_e         state_q, state_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              irq_q, irq_d;
  logic              conv_q;
  logic              trig_rise, all_rdy, accept, lost_inc, batch_full;
  logic [CNT_W:0]    evt_next;

  tv_edge_det i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (trig_i),
    .rise_o (trig_rise)
  );

  tv_ready_and #(.N_MOD(N_MOD)) i_rdy (
    .en_i      (mod_en_i),
    .rdy_i     (rdy_i),
    .all_rdy_o (all_rdy)
  );

  // cpu reset wins over a coincident trigger edge
  assign accept   = trig_rise & (state_q == ST_IDLE) & ~cpu_rst_i;
  assign lost_inc = trig_rise & (state_q != ST_IDLE) & ~cpu_rst_i;

  assign evt_next   = {1'b0, evt_cnt_o} + (CNT_W+1)'(1);
  assign batch_full = evt_next >= {1'b0, thresh_i};

  tv_sat_cnt #(.W(CNT_W)) i_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cpu_rst_i),
    .inc_i  (accept),
    .cnt_o  (evt_cnt_o)
  );

  tv_sat_cnt #(.W(LOST_W)) i_lost (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cpu_rst_i),
    .inc_i  (lost_inc),
    .cnt_o  (lost_cnt_o)
  );

  always_comb begin
    state_d = state_q;
    hold_d  = hold_q;
    irq_d   = irq_q;
    if (cpu_rst_i) irq_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (batch_full) begin
            state_d = ST_WAIT;
            irq_d   = 1'b1;
          end else begin
            state_d = ST_BUSY;
            hold_d  = HOLD_LD;
          end
        end
      end
      ST_BUSY: begin
        // hold-off lets modules drop a stale ready first
        if (hold_q != '0)  hold_d  = hold_q - HOLD_W'(1);
        else if (all_rdy)  state_d = ST_IDLE;
      end
      ST_WAIT: begin
        if (cpu_rst_i) begin
          state_d = ST_BUSY;
          hold_d  = HOLD_LD;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
      irq_q   <= 1'b0;
      conv_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
      irq_q   <= irq_d;
      conv_q  <= accept;
    end
  end

  assign veto_o = (state_q != ST_IDLE);
  assign conv_o = conv_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/trig_veto_chk.sv
module trig_veto_chk #(
  parameter int N_MOD  = 4,
  parameter int LOST_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_MOD-1:0]  mod_en_i,
  input logic [N_MOD-1:0]  rdy_i,
  input logic              cpu_rst_i,
  input logic              veto_o,
  input logic              conv_o,
  input logic              irq_o,
  input logic [LOST_W-1:0] lost_cnt_o
);
  logic all_ok;
  assign all_ok = &(rdy_i | ~mod_en_i);

  AST_CONV_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |=> !conv_o); // R2
  AST_CONV_WITH_VETO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |-> veto_o); // R2
  AST_VETO_RISE_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(veto_o) |-> conv_o); // R2
  AST_LOST_UNDER_VETO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!veto_o && !cpu_rst_i) |=> lost_cnt_o == $past(lost_cnt_o)); // R4
  AST_VETO_FALL_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(veto_o) |-> ($past(all_ok) && !$past(irq_o))); // R5
  AST_IRQ_WITH_VETO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> veto_o); // R7
  AST_IRQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !cpu_rst_i) |=> irq_o); // R8
  AST_IRQ_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_i |=> !irq_o); // R9
endmodule

bind trig_veto_ctrl trig_veto_chk #(.N_MOD(N_MOD), .LOST_W(LOST_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mod_en_i   (mod_en_i),
  .rdy_i      (rdy_i),
  .cpu_rst_i  (cpu_rst_i),
  .veto_o     (veto_o),
  .conv_o     (conv_o),
  .irq_o      (irq_o),
  .lost_cnt_o (lost_cnt_o)
);

// File: tb/test_trig_veto_ctrl.sv
module test_trig_veto_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_MOD  = 4;
  localparam int CNT_W  = 8;
  localparam int LOST_W = 3;
  localparam int HOLD   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic cpu_rst = 1'b0;
  logic [N_MOD-1:0] en = '1;
  logic [N_MOD-1:0] rdy = '1;
  logic [CNT_W-1:0] thresh = 8'd5;
  logic veto, conv, irq;
  logic [CNT_W-1:0]  evt;
  logic [LOST_W-1:0] lost;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_veto_ctrl #(.N_MOD(N_MOD), .CNT_W(CNT_W), .LOST_W(LOST_W), .HOLD(HOLD)) i_trig_veto_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .mod_en_i(en), .rdy_i(rdy),
    .cpu_rst_i(cpu_rst), .thresh_i(thresh), .veto_o(veto), .conv_o(conv),
    .irq_o(irq), .evt_cnt_o(evt), .lost_cnt_o(lost)
  );

  // reference model: 0 idle, 1 busy, 2 waiting for cpu
  int m_st = 0, m_hold = 0, m_evt = 0, m_lost = 0;
  bit m_prev = 0, m_conv = 0, m_irq = 0;
  localparam int LOST_MAX = (1 << LOST_W) - 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_hold = 0; m_evt = 0; m_lost = 0;
      m_prev = 0; m_conv = 0; m_irq = 0;
    end else begin
      bit rise, allr;
      rise = trig && !m_prev;
      m_prev = trig;
      allr = 1;
      for (int m = 0; m < N_MOD; m++) if (en[m] && !rdy[m]) allr = 0;
      m_conv = 0;
      if (cpu_rst) begin
        m_evt = 0; m_lost = 0; m_irq = 0;
      end
      case (m_st)
        0: if (rise && !cpu_rst) begin
             m_conv = 1;
             m_evt++;
             if (m_evt >= int'(thresh)) begin m_st = 2; m_irq = 1; end
             else begin m_st = 1; m_hold = HOLD; end
           end
        1: begin
             if (rise && !cpu_rst && m_lost < LOST_MAX) m_lost++;
             if (m_hold > 0) m_hold--;
             else if (allr) m_st = 0;
           end
        default: begin
             if (rise && !cpu_rst && m_lost < LOST_MAX) m_lost++;
             if (cpu_rst) begin m_st = 1; m_hold = HOLD; end
           end
      endcase
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // module emulation and per-cycle comparison
  int lat [N_MOD] = '{3, 5, 2, 4};
  int busy[N_MOD] = '{0, 0, 0, 0};
  bit stuck[N_MOD] = '{0, 0, 0, 0};

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", "conv_o", int'(conv), int'(m_conv));
      chk("R5", "veto_o", int'(veto), int'(m_st != 0));
      chk("R7", "irq_o", int'(irq), int'(m_irq));
      chk("R2", "evt_cnt_o", int'(evt), m_evt);
      chk("R4", "lost_cnt_o", int'(lost), m_lost);
    end
    for (int m = 0; m < N_MOD; m++) begin
      if (conv) busy[m] = lat[m];
      else if (busy[m] > 0) busy[m]--;
      rdy[m] = (busy[m] == 0) && !stuck[m];
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_trig(input int len);
    @(negedge clk) trig = 1'b1;
    cyc(len);
    trig = 1'b0;
  endtask

  task automatic pulse_cpu();
    @(negedge clk) cpu_rst = 1'b1;
    @(negedge clk) cpu_rst = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    cyc(3);
    chk("R1", "veto_o reset", int'(veto), 0);
    chk("R1", "conv_o reset", int'(conv), 0);
    chk("R1", "irq_o reset", int'(irq), 0);
    chk("R1", "evt_cnt_o reset", int'(evt), 0);
    chk("R1", "lost_cnt_o reset", int'(lost), 0);
    rst_n = 1'b1;
    cyc(2);

    pulse_trig(1);
    cyc(10);
    chk("R5", "veto released", int'(veto), 0);
    chk("R2", "one event", int'(evt), 1);

    pulse_trig(20); // R3 held trigger
    cyc(10);
    chk("R3", "held trigger counted once", int'(evt), 2);
    chk("R3", "held trigger not lost", int'(lost), 0);

    pulse_trig(1);
    cyc(1);
    pulse_trig(1);
    cyc(12);
    chk("R4", "second edge lost", int'(lost), 1);
    chk("R4", "lost edge not counted", int'(evt), 3);

    en = 4'b0111; stuck[3] = 1; // R6 disabled module stuck low
    cyc(2);
    pulse_trig(1);
    cyc(12);
    chk("R6", "disabled module ignored", int'(veto), 0);
    chk("R6", "event count", int'(evt), 4);

    pulse_trig(1);
    cyc(30);
    chk("R7", "irq at threshold", int'(irq), 1);
    chk("R8", "veto held under irq", int'(veto), 1);
    pulse_trig(1);
    cyc(2);
    chk("R4", "lost under irq", int'(lost), 2);

    @(negedge clk) begin trig = 1'b1; cpu_rst = 1'b1; end // R9 coincident
    @(negedge clk) begin trig = 1'b0; cpu_rst = 1'b0; end
    chk("R9", "irq cleared", int'(irq), 0);
    chk("R9", "evt cleared", int'(evt), 0);
    chk("R9", "lost cleared, trigger dropped", int'(lost), 0);
    chk("R9", "no conversion", int'(conv), 0);
    cyc(12);
    chk("R8", "veto released after ack", int'(veto), 0);

    en = '1; stuck[3] = 0;
    thresh = 8'd1;
    cyc(2);
    pulse_trig(1);
    cyc(2);
    chk("R7", "threshold one", int'(irq), 1);
    pulse_cpu();
    cyc(12);

    thresh = 8'd5;
    lat = '{60, 60, 60, 60};
    pulse_trig(1);
    for (int i = 0; i < 10; i++) begin
      cyc(1);
      pulse_trig(1);
    end
    cyc(1);
    chk("R4", "lost saturates", int'(lost), LOST_MAX);
    pulse_cpu();
    chk("R9", "busy reset clears lost", int'(lost), 0);
    chk("R9", "busy reset keeps veto", int'(veto), 1);
    cyc(80);
    chk("R5", "veto released late", int'(veto), 0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end
endmodule